// File: doc/BRIEF.md
# Banked GPIO Controller with Atomic Set/Clear Writes

This block controls 32 general-purpose pins from a small 32-bit register bus. The pins are grouped into two banks of sixteen. Each bank has its own window of feature registers, and the upper bank's window sits 0x80 above the lower one. Every per-pin feature is held in one bit: output level, output drive enable, input sampling enable, two output alternate-function selects and one input alternate-function select.

Writes are atomic per pin. In the written word, the lower half lists pins to set and the upper half lists pins to clear, so software never reads a register before it modifies it. Reads return the bank's sixteen feature bits in the low half of the data word, one cycle after the request.

The pad driver picks the pin's output from the first alternate source, the second alternate source or the output-level bit. Incoming pad levels pass through a two-stage synchronizer. Software sees them, and the input alternate function receives them, only on pins whose input sampling is enabled. Four pins are reserved and can never be set.

Top module: `gpio_banked`

## Requirements
- R1: Address bit 7 selects the bank: pin p (0..15) is served by the window at 0x00, and pin p+16 by the same offsets in the window at 0x80. The two banks hold independent state.
- R2: Writing a feature register with bit n = 1 and bit n+16 = 0 sets that feature bit for pin n of the bank. The offsets are 0x00 output level, 0x04 output enable, 0x0C output alternate 1, 0x10 output alternate 2, 0x14 input enable and 0x18 input alternate 1.
- R3: Writing bit n+16 = 1 clears that feature bit for pin n. Pins whose bits n and n+16 are both 0 keep their state.
- R4: If bits n and n+16 are both 1 in one write, the clear wins and the feature bit becomes 0.
- R5: When a read is requested, the bank's 16 feature bits appear in rdata[15:0] on the next cycle, and rdata[31:16] is 0.
- R6: Pins 23, 29, 30 and 31 (bits 7, 13, 14 and 15 of the upper bank) always read 0 in every feature register and never drive pad_oe, whatever is written.
- R7: Synchronous active-high reset clears every feature bit, so pad_oe, pad_out and aux_in_data are all 0 and every register reads 0.
- R8: pad_oe equals the output-enable bit of each pin. With both output alternate selects at 0, pad_out equals the output-level bit.
- R9: When output alternate 1 is selected, pad_out takes alt1_src. Otherwise, when output alternate 2 is selected, it takes alt2_src. Alternate 1 has priority.
- R10: The read-back register at offset 0x08 returns each pin's pad level after two synchronizer flops, gated by input enable (0 when input enable is 0). A pad change made just after an edge is not seen by a read sampled at the next edge, but it is seen by a read one cycle later.
- R11: aux_in_data carries the synchronized pad level on each pin whose input enable and input alternate 1 are both set, and 0 on every other pin.
- R12: Writes to offset 0x08 or to any unmapped offset change no feature bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 8 | Byte address: bit 7 is the bank, bits 6:0 the offset |
| bus_wdata | input | 32 | Write data: [15:0] set mask, [31:16] clear mask |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after bus_rd_en |
| pad_in | input | 32 | Asynchronous pad input levels |
| alt1_src | input | 32 | Output alternate function 1 data, per pin |
| alt2_src | input | 32 | Output alternate function 2 data, per pin |
| pad_out | output | 32 | Pad output level |
| pad_oe | output | 32 | Pad output drive enable |
| aux_in_data | output | 32 | Synchronized input routed to the input alternate function |

## Verification
The bench builds the block with its default parameters: two banks of sixteen pins, an 8-bit address and the reserved mask covering pins 23 and 29 to 31. Writing all-ones to the upper bank therefore exercises the reserved-pin filter together with bank decoding. The default two-stage synchronizer lets the bench time a pad change against back-to-back reads and catch a stage that is added or removed. A scoreboard queue of expected read words checks each response the cycle after it is requested. Output ports are compared directly after every write.

// File: rtl/gpio_banked_pkg.sv
package gpio_banked_pkg;

    localparam int NUM_BANKS  = 2;
    localparam int PPB        = 16;
    localparam int NPINS      = NUM_BANKS * PPB;
    localparam int BUS_W      = 2 * PPB;
    localparam int ADDR_W     = 8;
    localparam int BANK_BITS  = $clog2(NUM_BANKS);
    localparam int OFF_W      = ADDR_W - BANK_BITS;
    localparam int NUM_FEAT   = 6;
    localparam int SYNC_DEPTH = 2;

    localparam logic [NPINS-1:0] RSV_MASK = 32'hE080_0000;

    typedef enum logic [2:0] {
        FT_LEVEL = 3'd0,
        FT_DRIVE = 3'd1,
        FT_INEN  = 3'd2,
        FT_OALT1 = 3'd3,
        FT_OALT2 = 3'd4,
        FT_IALT1 = 3'd5
    } feat_e;

    typedef struct packed {
        logic  is_feat;
        logic  is_rb;
        feat_e feat;
    } dec_t;

    function automatic dec_t decode_off(input logic [OFF_W-1:0] off);
        dec_t d;
        d.is_feat = 1'b1;
        d.is_rb   = 1'b0;
        d.feat    = FT_LEVEL;
        case (off)
            7'h00:   d.feat = FT_LEVEL;
            7'h04:   d.feat = FT_DRIVE;
            7'h08: begin
                d.is_feat = 1'b0;
                d.is_rb   = 1'b1;
            end
            7'h0C:   d.feat = FT_OALT1;
            7'h10:   d.feat = FT_OALT2;
            7'h14:   d.feat = FT_INEN;
            7'h18:   d.feat = FT_IALT1;
            default: d.is_feat = 1'b0;
        endcase
        return d;
    endfunction

    function automatic logic [PPB-1:0] apply_sc(input logic [PPB-1:0] cur,
                                                 input logic [BUS_W-1:0] w);
        return (cur | w[PPB-1:0]) & ~w[BUS_W-1:PPB];
    endfunction

endpackage

// File: rtl/gpio_banked_bank.sv
module gpio_banked_bank
    import gpio_banked_pkg::*;
#(
    parameter logic [PPB-1:0] RSV = '0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  feat_e                         feat_sel,
    input  logic [BUS_W-1:0]              wdata,
    output logic [NUM_FEAT-1:0][PPB-1:0]  feat_q
);

    for (genvar f = 0; f < NUM_FEAT; f++) begin : g_feat
        logic [PPB-1:0] bits_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bits_q <= '0;
            end else if (wr_en && (feat_sel == feat_e'(f))) begin
                bits_q <= apply_sc(bits_q, wdata) & ~RSV;
            end
        end
        assign feat_q[f] = bits_q;
    end

endmodule

// File: rtl/gpio_banked_sync.sv
module gpio_banked_sync #(
    parameter int W     = 32,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [DEPTH-1:0][W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < DEPTH; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[DEPTH-1];

endmodule

// File: rtl/gpio_banked_padmux.sv
module gpio_banked_padmux #(
    parameter int W = 32
) (
    input  logic [W-1:0] level,
    input  logic [W-1:0] drive,
    input  logic [W-1:0] oalt1,
    input  logic [W-1:0] oalt2,
    input  logic [W-1:0] alt1_src,
    input  logic [W-1:0] alt2_src,
    input  logic [W-1:0] sync_lvl,
    input  logic [W-1:0] inen,
    input  logic [W-1:0] ialt1,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] readback,
    output logic [W-1:0] aux_in
);

    for (genvar p = 0; p < W; p++) begin : g_pin
        always_comb begin
            if (oalt1[p]) begin
                pad_out[p] = alt1_src[p];
            end else if (oalt2[p]) begin
                pad_out[p] = alt2_src[p];
            end else begin
                pad_out[p] = level[p];
            end
        end
    end

    assign pad_oe   = drive;
    assign readback = sync_lvl & inen;
    assign aux_in   = sync_lvl & inen & ialt1;

endmodule

// File: rtl/gpio_banked.sv
module gpio_banked
    import gpio_banked_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    input  logic [NPINS-1:0]  alt1_src,
    input  logic [NPINS-1:0]  alt2_src,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  aux_in_data
);

    logic [BANK_BITS-1:0] bank_idx;
    logic [OFF_W-1:0]     off;
    dec_t                 dec;

    assign bank_idx = bus_addr[ADDR_W-1 -: BANK_BITS];
    assign off      = bus_addr[OFF_W-1:0];
    assign dec      = decode_off(off);

    logic [NUM_BANKS-1:0][NUM_FEAT-1:0][PPB-1:0] bank_feat;
    logic [NUM_FEAT-1:0][NPINS-1:0]              pin_feat;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_banked_bank #(
            .RSV(RSV_MASK[b*PPB +: PPB])
        ) bank_i (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (bus_wr_en && dec.is_feat && (bank_idx == BANK_BITS'(b))),
            .feat_sel (dec.feat),
            .wdata    (bus_wdata),
            .feat_q   (bank_feat[b])
        );
        for (genvar f = 0; f < NUM_FEAT; f++) begin : g_flat
            assign pin_feat[f][b*PPB +: PPB] = bank_feat[b][f];
        end
    end

    logic [NPINS-1:0] level_all, drive_all, inen_all;
    logic [NPINS-1:0] oalt1_all, oalt2_all, ialt1_all;
    logic [NPINS-1:0] sync_lvl, readback_all;

    assign level_all = pin_feat[FT_LEVEL];
    assign drive_all = pin_feat[FT_DRIVE];
    assign inen_all  = pin_feat[FT_INEN];
    assign oalt1_all = pin_feat[FT_OALT1];
    assign oalt2_all = pin_feat[FT_OALT2];
    assign ialt1_all = pin_feat[FT_IALT1];

    gpio_banked_sync #(
        .W     (NPINS),
        .DEPTH (SYNC_DEPTH)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (sync_lvl)
    );

    gpio_banked_padmux #(
        .W (NPINS)
    ) mux_i (
        .level    (level_all),
        .drive    (drive_all),
        .oalt1    (oalt1_all),
        .oalt2    (oalt2_all),
        .alt1_src (alt1_src),
        .alt2_src (alt2_src),
        .sync_lvl (sync_lvl),
        .inen     (inen_all),
        .ialt1    (ialt1_all),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .readback (readback_all),
        .aux_in   (aux_in_data)
    );

    logic [PPB-1:0] rd_word;

    always_comb begin
        rd_word = '0;
        if (dec.is_feat) begin
            rd_word = bank_feat[bank_idx][dec.feat];
        end else if (dec.is_rb) begin
            rd_word = readback_all[bank_idx*PPB +: PPB];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd_en) begin
            bus_rdata <= {{(BUS_W-PPB){1'b0}}, rd_word};
        end
    end

endmodule

// File: rtl/gpio_banked_chk.sv
module gpio_banked_chk
    import gpio_banked_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  alt1_src,
    input logic [NPINS-1:0]  alt2_src,
    input logic [NPINS-1:0]  oalt1_all,
    input logic [NPINS-1:0]  oalt2_all,
    input logic [NPINS-1:0]  inen_all,
    input logic [NPINS-1:0]  readback_all
);

    a_r2_set_drive: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && bus_addr == 8'h04 && bus_wdata[0] && !bus_wdata[16]) |=> pad_oe[0]);

    a_r4_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && bus_addr == 8'h04 && bus_wdata[16]) |=> !pad_oe[0]);

    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_en |=> $stable(pad_oe));

    a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[BUS_W-1:PPB] == '0);

    a_r6_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & RSV_MASK) == '0);

    a_r7_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pad_oe == '0 && bus_rdata == '0));

    a_r9_alt1_wins: assert property (@(posedge clk) disable iff (rst)
        ((pad_out ^ alt1_src) & oalt1_all) == '0);

    a_r9_alt2_next: assert property (@(posedge clk) disable iff (rst)
        ((pad_out ^ alt2_src) & oalt2_all & ~oalt1_all) == '0);

    a_r10_gated_rb: assert property (@(posedge clk) disable iff (rst)
        (readback_all & ~inen_all) == '0);

endmodule

bind gpio_banked gpio_banked_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .bus_wr_en    (bus_wr_en),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .pad_out      (pad_out),
    .pad_oe       (pad_oe),
    .alt1_src     (alt1_src),
    .alt2_src     (alt2_src),
    .oalt1_all    (oalt1_all),
    .oalt2_all    (oalt2_all),
    .inen_all     (inen_all),
    .readback_all (readback_all)
);

// File: tb/gpio_banked_tb_top.sv
module gpio_banked_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = 32'hA5A5_5A5A;
    logic [31:0] alt1_src = 32'hFFFF_FFFF;
    logic [31:0] alt2_src = 32'h0000_0000;
    logic [31:0] pad_out, pad_oe, aux_in_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       req;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #5 clk = ~clk;

    gpio_banked dut_i (
        .clk         (clk),
        .rst         (rst),
        .bus_wr_en   (bus_wr_en),
        .bus_rd_en   (bus_rd_en),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .pad_in      (pad_in),
        .alt1_src    (alt1_src),
        .alt2_src    (alt2_src),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe),
        .aux_in_data (aux_in_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        sb_item_t it;
        @(negedge clk);
        it.exp = exp;
        it.req = req;
        sb_q.push_back(it);
        bus_rd_en = 1'b1;
        bus_addr  = a;
        @(negedge clk);
        bus_rd_en = 1'b0;
    endtask

    // monitor: pops the expected word the cycle after each read strobe
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd_en && !rst) begin
                @(negedge clk);
                if (sb_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R5 unexpected read actual=%h expected=none", bus_rdata);
                end else begin
                    sb_item_t it;
                    it = sb_q.pop_front();
                    check(it.req, bus_rdata, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R7: reset state
        check("R7 oe", pad_oe, 32'h0);
        check("R7 out", pad_out, 32'h0);
        rd(8'h04, 32'h0, "R7 read low drive");
        rd(8'h84, 32'h0, "R7 read high drive");

        // R2, R4, R3: set, clear priority, clear
        wr(8'h04, 32'h0000_00F1);
        check("R2 set drive", pad_oe, 32'h0000_00F1);
        wr(8'h04, 32'h0001_0001);
        check("R4 clear wins", pad_oe, 32'h0000_00F0);
        wr(8'h04, 32'h0010_0000);
        check("R3 clear one", pad_oe, 32'h0000_00E0);
        wr(8'h00, 32'h0000_0050);
        check("R8 level", pad_out, 32'h0000_0050);
        check("R8 drive", pad_oe, 32'h0000_00E0);

        // R1, R6: high bank window and reserved pins
        wr(8'h84, 32'h0000_FFFF);
        check("R1 R6 high drive", pad_oe, 32'h1F7F_00E0);
        rd(8'h84, 32'h0000_1F7F, "R5 R6 high read");
        rd(8'h04, 32'h0000_00E0, "R1 low read");

        // R9: output alternate selection
        wr(8'h0C, 32'h0000_0020);
        wr(8'h10, 32'h0000_0060);
        check("R9 alt priority", pad_out, 32'h0000_0030);
        rd(8'h0C, 32'h0000_0020, "R2 alt1 read");
        rd(8'h10, 32'h0000_0060, "R2 alt2 read");

        // R10: read-back gating and synchronizer latency
        rd(8'h08, 32'h0, "R10 gated off");
        wr(8'h14, 32'h0000_FFFF);
        wr(8'h94, 32'h0000_FFFF);
        repeat (3) @(negedge clk);
        rd(8'h08, 32'h0000_5A5A, "R10 low level");
        rd(8'h88, 32'h0000_0525, "R10 R6 high level");
        rd(8'h94, 32'h0000_1F7F, "R6 high inen");
        pad_in = 32'hA5A5_FFFF;
        rd(8'h08, 32'h0000_5A5A, "R10 not yet");
        rd(8'h08, 32'h0000_FFFF, "R10 after two");

        // R11: input alternate routing
        wr(8'h18, 32'h0000_0008);
        check("R11 routed", aux_in_data, 32'h0000_0008);
        wr(8'h14, 32'h0008_0000);
        check("R11 gated", aux_in_data, 32'h0);
        rd(8'h08, 32'h0000_FFF7, "R10 one pin off");

        // R12: writes to read-back and unmapped offsets
        wr(8'h08, 32'hFFFF_0000);
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h7C, 32'hFFFF_0000);
        check("R12 drive kept", pad_oe, 32'h1F7F_00E0);
        check("R12 out kept", pad_out, 32'h0000_0030);
        rd(8'h00, 32'h0000_0050, "R12 level kept");
        rd(8'h14, 32'h0000_FFF7, "R12 inen kept");
        rd(8'h18, 32'h0000_0008, "R12 ialt kept");

        // R6: reserved level bits in high bank
        wr(8'h80, 32'h0000_FFFF);
        check("R6 high level", pad_out, 32'h1F7F_0030);
        rd(8'h80, 32'h0000_1F7F, "R6 high level read");

        // R7: reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R7 oe after", pad_oe, 32'h0);
        check("R7 out after", pad_out, 32'h0);
        check("R7 aux after", aux_in_data, 32'h0);
        rd(8'h84, 32'h0, "R7 high read after");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R5 reads missing actual=%0d expected=0", sb_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule